// File: doc/BRIEF.md
# PWM Output Router with Gate-Drive Chopping

This block takes six raw PWM signals and turns them into the six gate-drive pins of a three-phase inverter. The signals are ordered as three complementary pairs: a high side and a low side for each of phases A, B and C. The PWM waveforms are generated upstream. This block only decides what reaches the pins. A per-output enable word can force any output inactive, which supports commutated and segment-based modulation schemes. Two independent enables apply a high-frequency carrier to the high-side or low-side "on" phases, for gate drivers coupled through a transformer.

The carrier is a 50% square wave produced by a programmable clock divider. The divided-down "on" vector is registered once. After that register, two combinational controls act on it. A trip input drives every pin to its off level in the same cycle. A polarity input then sets whether "on" is a 1 or a 0 at the pins. Because polarity is applied last, it also sets the level of the tripped state.

Top module: `pwm_out_ctrl`

## Requirements
- R1: Output enable bit i of `seg_en` gates output i. Bit positions: 0 = A high, 1 = A low, 2 = B high, 3 = B low, 4 = C high, 5 = C low. When bit i is cleared, output i is off on the cycle after the clock edge that sampled the cleared bit.
- R2: When an output is enabled, chopping is off and trip is low, `pin_out[i]` shows `pwm_raw[i]` as sampled at the previous clock edge. This is one register of latency.
- R3: When `chop_hi_en` is 1, the even (high-side) outputs are on only while the carrier was high at the sampling edge. The odd outputs are unaffected by this enable.
- R4: When `chop_lo_en` is 1, the odd (low-side) outputs are on only while the carrier was high at the sampling edge. The even outputs are unaffected by this enable.
- R5: After reset the carrier starts high. The divider counts up from 0. At each edge where the count is greater than or equal to `chop_div`, the count returns to 0 and the carrier toggles. Each carrier half-period is therefore `chop_div`+1 cycles.
- R6: With `pol_hi` = 1, "on" is driven as 1 and "off" as 0. With `pol_hi` = 0, every pin level is inverted. Polarity acts combinationally on the pins in the same cycle.
- R7: While `trip` is 1, every pin is held at its off level in the same cycle (0 for `pol_hi` = 1, 1 for `pol_hi` = 0). This holds regardless of the raw signals, the enables and the carrier.
- R8: While `rst_n` is low, the registered "on" vector is cleared, so all pins show the off level for the current polarity.
- R9: Lowering `chop_div` below the current count makes the carrier toggle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_raw | input | 6 | Raw PWM signals, on = 1, ordered AH, AL, BH, BL, CH, CL from bit 0 |
| seg_en | input | 6 | Per-output enable, same bit order |
| chop_hi_en | input | 1 | Apply carrier to high-side outputs |
| chop_lo_en | input | 1 | Apply carrier to low-side outputs |
| chop_div | input | DIV_W | Carrier half-period minus one, in clock cycles |
| pol_hi | input | 1 | 1 = on is high at the pins, 0 = on is low |
| trip | input | 1 | Fault input; forces all pins off |
| pin_out | output | 6 | Gate-drive pins |

## Verification
On every cycle, the assertions check several relations. A cleared enable bit never lets its output register set. A low carrier never lets a chopped side through. The divider either advances by one or wraps, and toggles the carrier exactly at the wrap. A trip always leaves the pins at the polarity-dependent off level. Only the bench scenarios can show the rest: that the carrier's phase starts high out of reset, that its exact half-period follows `chop_div`, that the two chop enables are independent, and that polarity inverts the whole vector. They also show the one-cycle latency of the raw path and the reset-time pin levels under both polarities.

// File: rtl/pwm_out_pkg.sv
// Package: shared constants and helpers for the PWM output router.
// Assumes outputs are ordered as high/low pairs per phase, high side on even bits.
package pwm_out_pkg;

    localparam int PHASES = 3;
    localparam int OUT_W  = 2 * PHASES;

    // Build a mask selecting the high-side (hi=1) or low-side (hi=0) outputs.
    function automatic logic [OUT_W-1:0] side_mask(input logic hi);
        logic [OUT_W-1:0] m;
        for (int i = 0; i < OUT_W; i++) begin
            m[i] = ((i % 2) == 0) ? hi : ~hi;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_carrier_gen.sv
// Module: pwm_carrier_gen
// Generates the 50% chopping carrier from a programmable divider.
// Assumes: synchronous active-low reset; the carrier starts high; a wrap
// happens when the count reaches or exceeds the divide value, so lowering
// the divide value mid-period takes effect at the next edge.
module pwm_carrier_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             carrier
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Wrap condition for the divide counter.
    assign wrap = (cnt_q >= div_val);

    // Divider count and carrier toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            carrier <= 1'b1;
        end else if (wrap) begin
            cnt_q   <= '0;
            carrier <= ~carrier;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    AST_CARRIER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= div_val) |=> (carrier != $past(carrier)) && (cnt_q == '0)); // R5
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < div_val) |=> (cnt_q == $past(cnt_q) + 1'b1) && $stable(carrier)); // R9

endmodule

// File: rtl/pwm_seg_chop.sv
// Module: pwm_seg_chop
// Applies per-output enables and optional carrier chopping to the raw PWM
// vector, and registers the resulting "on" vector.
// Assumes: raw on = 1; high side on even bits; synchronous active-low reset.
module pwm_seg_chop
    import pwm_out_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] raw,
    input  logic [OUT_W-1:0] seg,
    input  logic             chop_hi,
    input  logic             chop_lo,
    input  logic             carrier,
    output logic [OUT_W-1:0] on_q
);

    logic [OUT_W-1:0] chop_sel;
    logic [OUT_W-1:0] on_d;

    // Per-output gating: enable, then carrier if that side is chopped.
    for (genvar i = 0; i < OUT_W; i++) begin : g_out
        if ((i % 2) == 0) begin : g_hi
            assign chop_sel[i] = chop_hi;
        end else begin : g_lo
            assign chop_sel[i] = chop_lo;
        end
        assign on_d[i] = raw[i] & seg[i] & (carrier | ~chop_sel[i]);
    end

    // Register the gated on vector.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= '0;
        else        on_q <= on_d;
    end

    AST_SEG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((on_q & ~$past(seg)) == '0)); // R1
    AST_CHOP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_hi && !carrier) |=> ((on_q & side_mask(1'b1)) == '0)); // R3
    AST_CHOP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_lo && !carrier) |=> ((on_q & side_mask(1'b0)) == '0)); // R4

endmodule

// File: rtl/pwm_pin_drive.sv
// Module: pwm_pin_drive
// Final pin stage: trip override, then polarity, both combinational so a
// fault reaches the pins without waiting for a clock edge.
// Assumes: on_q is a registered on = 1 vector.
module pwm_pin_drive
    import pwm_out_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] on_q,
    input  logic             trip,
    input  logic             pol_hi,
    output logic [OUT_W-1:0] pin_out
);

    logic [OUT_W-1:0] live;

    // Trip masks everything off, then polarity sets the pin levels.
    always_comb begin
        live    = on_q & ~{OUT_W{trip}};
        pin_out = pol_hi ? live : ~live;
    end

    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (pin_out == {OUT_W{~pol_hi}})); // R7

endmodule

// File: rtl/pwm_out_ctrl.sv
// Module: pwm_out_ctrl (top)
// Routes six raw PWM signals to gate-drive pins with per-output enables,
// independent high/low side carrier chopping, trip override and polarity.
// Assumes: synchronous active-low reset; one register between raw and pins.
module pwm_out_ctrl
    import pwm_out_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] pwm_raw,
    input  logic [OUT_W-1:0] seg_en,
    input  logic             chop_hi_en,
    input  logic             chop_lo_en,
    input  logic [DIV_W-1:0] chop_div,
    input  logic             pol_hi,
    input  logic             trip,
    output logic [OUT_W-1:0] pin_out
);

    logic             carrier;
    logic [OUT_W-1:0] on_q;

    pwm_carrier_gen #(.DIV_W(DIV_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (chop_div),
        .carrier (carrier)
    );

    pwm_seg_chop u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (pwm_raw),
        .seg     (seg_en),
        .chop_hi (chop_hi_en),
        .chop_lo (chop_lo_en),
        .carrier (carrier),
        .on_q    (on_q)
    );

    pwm_pin_drive u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_q    (on_q),
        .trip    (trip),
        .pol_hi  (pol_hi),
        .pin_out (pin_out)
    );

endmodule

// File: tb/tb_pwm_out_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_out_ctrl;

    localparam int W     = 6;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [W-1:0]     pwm_raw, seg_en, pin_out;
    logic             chop_hi_en, chop_lo_en, pol_hi, trip;
    logic [DIV_W-1:0] chop_div;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // Independent carrier model
    bit         car_m;
    int         cnt_m;

    always #4 clk = ~clk;

    pwm_out_ctrl #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .seg_en(seg_en),
        .chop_hi_en(chop_hi_en), .chop_lo_en(chop_lo_en), .chop_div(chop_div),
        .pol_hi(pol_hi), .trip(trip), .pin_out(pin_out)
    );

    task automatic direct_check(input logic [W-1:0] exp, input string tag);
        checks++;
        if (pin_out !== exp) begin
            errors++;
            $display("FAIL %s: pin_out=%b expected=%b", tag, pin_out, exp);
        end
    endtask

    // Driver: applies one cycle of inputs and pushes the expected pins.
    task automatic cyc(input logic [W-1:0] raw, input logic [W-1:0] seg,
                       input bit ch, input bit cl, input int div,
                       input bit pol, input bit trp, input string tag);
        logic [W-1:0] cm, on, live;
        item_t it;
        pwm_raw = raw; seg_en = seg; chop_hi_en = ch; chop_lo_en = cl;
        chop_div = DIV_W'(div); pol_hi = pol; trip = trp;
        cm   = (ch ? 6'b010101 : 6'b0) | (cl ? 6'b101010 : 6'b0);
        on   = raw & seg & ~(cm & {W{~car_m}});
        live = trp ? '0 : on;
        it.exp = pol ? live : ~live;
        it.tag = tag;
        sb_q.push_back(it);
        if (cnt_m >= div) begin
            cnt_m = 0;
            car_m = ~car_m;
        end else begin
            cnt_m++;
        end
        @(negedge clk);
    endtask

    // Monitor: compares pins against the scoreboard after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (pin_out !== it.exp) begin
                    errors++;
                    $display("FAIL %s: pin_out=%b expected=%b", it.tag, pin_out, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwm_raw = '1; seg_en = '1; chop_hi_en = 0; chop_lo_en = 0;
        chop_div = 8'd3; pol_hi = 1'b1; trip = 1'b0;
        car_m = 1'b1; cnt_m = 0;
        repeat (3) @(negedge clk);
        direct_check(6'b000000, "R8 reset pol high");
        pol_hi = 1'b0; #1;
        direct_check(6'b111111, "R8 reset pol low");
        pol_hi = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 pass-through patterns
        cyc(6'b101010, '1, 0, 0, 3, 1, 0, "R2 pattern a");
        cyc(6'b010101, '1, 0, 0, 3, 1, 0, "R2 pattern b");
        cyc(6'b110011, '1, 0, 0, 3, 1, 0, "R2 pattern c");
        cyc(6'b000000, '1, 0, 0, 3, 1, 0, "R2 all off");
        // R1 segment masking
        cyc(6'b111111, 6'b000011, 0, 0, 3, 1, 0, "R1 only phase A");
        cyc(6'b111111, 6'b100100, 0, 0, 3, 1, 0, "R1 mixed mask");
        cyc(6'b111111, 6'b000000, 0, 0, 3, 1, 0, "R1 all masked");
        // R3 / R5 high-side chopping, half-period 4
        for (int k = 0; k < 12; k++) cyc(6'b111111, '1, 1, 0, 3, 1, 0, "R3 R5 hi chop");
        // R4 low-side chopping, half-period 2
        for (int k = 0; k < 10; k++) cyc(6'b111111, '1, 0, 1, 1, 1, 0, "R4 lo chop");
        // Both sides, divide 0
        for (int k = 0; k < 6; k++) cyc(6'b111111, '1, 1, 1, 0, 1, 0, "R5 div zero");
        // R9 divide lowered mid-period
        for (int k = 0; k < 5; k++) cyc(6'b111111, '1, 1, 1, 9, 1, 0, "R9 long period");
        for (int k = 0; k < 6; k++) cyc(6'b111111, '1, 1, 1, 1, 1, 0, "R9 lowered div");
        // R6 polarity low
        cyc(6'b100110, '1, 0, 0, 3, 0, 0, "R6 pol low a");
        cyc(6'b011001, 6'b001111, 0, 0, 3, 0, 0, "R6 pol low masked");
        cyc(6'b111111, '1, 1, 0, 3, 0, 0, "R6 pol low chopped");
        // R7 trip under both polarities
        cyc(6'b111111, '1, 0, 0, 3, 1, 1, "R7 trip pol high");
        cyc(6'b111111, '1, 1, 1, 3, 0, 1, "R7 trip pol low");
        cyc(6'b111111, '1, 0, 0, 3, 1, 0, "R7 trip released");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule